// File: doc/BRIEF.md
# Byte-lane asynchronous SRAM controller

This block connects a simple synchronous request bus to an external asynchronous static RAM of 65,536 sixteen-bit words. The RAM has a separate enable for each byte. Each request carries a word address, write data, a read/write flag and a two-bit lane mask. The controller converts the request into the active-low chip, write, output and byte-enable strobes. It also drives the data pins through an output-enable, because the pad is bidirectional.

Each access holds its strobe for a wait count given on an input, so one design covers fast and slow parts. A write has one setup cycle before the write strobe and one hold cycle after it. A read captures the data on the last strobe cycle and returns it with a one-cycle valid pulse; lanes not named in the mask return zero. Between accesses the chip enable is high, so the RAM stays in standby.

Top module: `sram16_ctrl`

## Requirements
- R1: Out of reset, and whenever idle, ram_ce_n, ram_we_n, ram_oe_n, ram_ub_n and ram_lb_n are 1, ram_dq_oe is 0, req_ready is 1 and rsp_valid is 0.
- R2: A write accepted with wait count W (sampled at acceptance) holds ram_ce_n low for W+3 cycles: one setup cycle with ram_we_n high, then ram_we_n low for W+1 cycles, then one hold cycle with ram_we_n high. req_ready returns W+4 cycles after the accepting edge.
- R3: Throughout a write's chip-enable window, ram_addr equals the request address and ram_dq_out equals the write data. ram_lb_n is low exactly when mask bit 0 is set (data bits 7:0), and ram_ub_n is low exactly when mask bit 1 is set (bits 15:8). Lanes left out keep their old contents.
- R4: A read accepted with wait count W holds ram_ce_n and ram_oe_n low with ram_we_n high for W+1 cycles. rsp_valid is then high for exactly one cycle, W+2 cycles after acceptance, and req_ready returns one cycle later.
- R5: Read data on enabled lanes equals the stored word; lanes whose mask bit is clear read as zero, whatever the pins carry.
- R6: ram_dq_oe is high only during a write's chip-enable window. It is never high while ram_oe_n is low, and it is low in the cycle before any cycle in which ram_oe_n is low.
- R7: A request whose mask is 0 asserts no strobe. It finishes in one cycle; for a read, rsp_valid pulses with zero data one cycle after acceptance.
- R8: req_ready is high only when idle. A request held valid while the controller is busy is not taken and leaves memory untouched.
- R9: The wait count covers 0 up to 2**WAIT_W-1, so the strobe can be stretched to 2**WAIT_W cycles for the slowest parts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request taken on this edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| req_mask | input | 2 | Lane mask, bit 0 low byte, bit 1 high byte |
| access_wait | input | WAIT_W | Extra strobe cycles for the access |
| rsp_valid | output | 1 | One-cycle read completion pulse |
| rsp_rdata | output | DATA_W | Read data, unselected lanes zero |
| ram_addr | output | ADDR_W | RAM address pins |
| ram_ce_n | output | 1 | Chip enable, active low |
| ram_we_n | output | 1 | Write enable, active low |
| ram_oe_n | output | 1 | Output enable, active low |
| ram_ub_n | output | 1 | High byte enable, active low |
| ram_lb_n | output | 1 | Low byte enable, active low |
| ram_dq_out | output | DATA_W | Data toward the pad |
| ram_dq_oe | output | 1 | Pad output enable |
| ram_dq_in | input | DATA_W | Data from the pad |

## Verification
The bench sweeps every lane mask, for both reads and writes, over wait counts 0 to 3 and the maximum 15. It uses five addresses, including all-zero and all-one. The RAM model puts fixed non-zero patterns on floating lanes, so a missing lane clear shows up as wrong data. Partial writes are checked by reading back the full word, which separates a correct merge from a whole-word overwrite. Cycle counts of each strobe separate an off-by-one in the wait counter from a missing setup or hold cycle. A request held valid while the controller is busy checks that nothing is taken before ready.

// File: rtl/sram16_ctrl.sv
module sram16_ctrl #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [1:0]        req_mask,
  input  logic [WAIT_W-1:0] access_wait,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] ram_addr,
  output logic              ram_ce_n,
  output logic              ram_we_n,
  output logic              ram_oe_n,
  output logic              ram_ub_n,
  output logic              ram_lb_n,
  output logic [DATA_W-1:0] ram_dq_out,
  output logic              ram_dq_oe,
  input  logic [DATA_W-1:0] ram_dq_in
);
  localparam int LANE_W = DATA_W / 2;

  typedef enum logic [2:0] {
    S_IDLE, S_WSET, S_WSTB, S_WHLD, S_RSTB, S_DONE
  } state_t;

  state_t            st;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic [1:0]        mask_q;
  logic              wr_q;
  logic [WAIT_W-1:0] cnt;
  logic [DATA_W-1:0] lane_keep;
  logic              in_write, in_access;

  assign lane_keep = {{LANE_W{mask_q[1]}}, {LANE_W{mask_q[0]}}};
  assign in_write  = (st == S_WSET) || (st == S_WSTB) || (st == S_WHLD);
  assign in_access = in_write || (st == S_RSTB);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      mask_q  <= '0;
      wr_q    <= 1'b0;
      cnt     <= '0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          addr_q  <= req_addr;
          wdata_q <= req_wdata;
          mask_q  <= req_mask;
          wr_q    <= req_write;
          cnt     <= access_wait;
          if (req_mask == 2'b00) begin
            rdata_q <= '0;
            st      <= S_DONE;
          end else begin
            st <= req_write ? S_WSET : S_RSTB;
          end
        end
        S_WSET: st <= S_WSTB;
        S_WSTB: if (cnt == '0) st <= S_WHLD; else cnt <= cnt - 1'b1;
        S_WHLD: st <= S_IDLE;
        S_RSTB: if (cnt == '0) begin
          rdata_q <= ram_dq_in & lane_keep;
          st      <= S_DONE;
        end else begin
          cnt <= cnt - 1'b1;
        end
        S_DONE: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign req_ready  = (st == S_IDLE);
  assign rsp_valid  = (st == S_DONE) && !wr_q;
  assign rsp_rdata  = rdata_q;
  assign ram_addr   = addr_q;
  assign ram_ce_n   = !in_access;
  assign ram_we_n   = (st != S_WSTB);
  assign ram_oe_n   = (st != S_RSTB);
  assign ram_ub_n   = !(in_access && mask_q[1]);
  assign ram_lb_n   = !(in_access && mask_q[0]);
  assign ram_dq_out = wdata_q;
  assign ram_dq_oe  = in_write;
endmodule

module sram16_ctrl_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] ram_addr,
  input logic              ram_ce_n,
  input logic              ram_we_n,
  input logic              ram_oe_n,
  input logic              ram_ub_n,
  input logic              ram_lb_n,
  input logic [DATA_W-1:0] ram_dq_out,
  input logic              ram_dq_oe
);
  assert_no_contention_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ram_dq_oe |-> (ram_oe_n && !ram_ce_n));
  assert_bus_turnaround_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ram_oe_n) |-> !$past(ram_dq_oe));
  assert_we_inside_ce_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_we_n |-> (!ram_ce_n && ram_oe_n && ram_dq_oe));
  assert_we_setup_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ram_we_n) |-> (!$past(ram_ce_n) && $stable(ram_addr) && $stable(ram_dq_out)));
  assert_we_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ram_we_n) |-> (!ram_ce_n && $stable(ram_addr) && $stable(ram_ub_n) && $stable(ram_lb_n)));
  assert_addr_steady_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ram_ce_n && !$past(ram_ce_n)) |-> ($stable(ram_addr) && $stable(ram_ub_n) && $stable(ram_lb_n)));
  assert_read_strobes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_oe_n |-> (ram_we_n && !ram_ce_n));
  assert_single_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  assert_lane_named_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_ce_n |-> !(ram_ub_n && ram_lb_n));
  assert_idle_standby_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (ram_ce_n && !ram_dq_oe && !rsp_valid));
  assert_busy_not_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_ce_n |-> !req_ready);
endmodule

bind sram16_ctrl sram16_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .ram_addr(ram_addr), .ram_ce_n(ram_ce_n), .ram_we_n(ram_we_n),
  .ram_oe_n(ram_oe_n), .ram_ub_n(ram_ub_n), .ram_lb_n(ram_lb_n),
  .ram_dq_out(ram_dq_out), .ram_dq_oe(ram_dq_oe)
);

// File: tb/sram16_ctrl_bench.sv
module sram16_ctrl_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        req_valid = 0, req_write = 0;
  logic [15:0] req_addr = 0, req_wdata = 0;
  logic [1:0]  req_mask = 0;
  logic [3:0]  access_wait = 0;
  logic        req_ready, rsp_valid;
  logic [15:0] rsp_rdata, ram_addr, ram_dq_out, ram_dq_in;
  logic        ram_ce_n, ram_we_n, ram_oe_n, ram_ub_n, ram_lb_n, ram_dq_oe;

  int checks = 0, failures = 0;
  logic [15:0] rmem [16];
  logic [15:0] shadow [16];
  logic        last_oe = 0;

  always #5 clk = ~clk;

  sram16_ctrl u_sram16_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_mask(req_mask), .access_wait(access_wait), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .ram_addr(ram_addr), .ram_ce_n(ram_ce_n),
    .ram_we_n(ram_we_n), .ram_oe_n(ram_oe_n), .ram_ub_n(ram_ub_n),
    .ram_lb_n(ram_lb_n), .ram_dq_out(ram_dq_out), .ram_dq_oe(ram_dq_oe),
    .ram_dq_in(ram_dq_in)
  );

  function automatic int slot(input logic [15:0] a);
    return int'({a[15], a[2:0]});
  endfunction

  function automatic logic [15:0] lanes(input logic [1:0] m);
    return {{8{m[1]}}, {8{m[0]}}};
  endfunction

  logic rd_on;
  assign rd_on = !ram_ce_n && !ram_oe_n && ram_we_n;
  assign ram_dq_in = {(rd_on && !ram_ub_n) ? rmem[slot(ram_addr)][15:8] : 8'hA5,
                      (rd_on && !ram_lb_n) ? rmem[slot(ram_addr)][7:0]  : 8'h5A};

  always @(posedge clk) begin
    if (!ram_ce_n && !ram_we_n) begin
      if (!ram_lb_n) rmem[slot(ram_addr)][7:0]  <= ram_dq_oe ? ram_dq_out[7:0]  : 8'hEE;
      if (!ram_ub_n) rmem[slot(ram_addr)][15:8] <= ram_dq_oe ? ram_dq_out[15:8] : 8'hEE;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic access(input bit wr, input logic [15:0] a, input logic [15:0] d,
                        input logic [1:0] m, input logic [3:0] w, input bit junk);
    int cyc = 0, ce_lo = 0, we_lo = 0, oe_lo = 0, rsp_n = 0, rsp_cyc = -1, first_we = -1;
    int end_exp, ce_exp;
    bit pin_bad = 0, gap_bad = 0;
    logic [15:0] got = 0, exp_rd;
    req_write = wr; req_addr = a; req_wdata = d; req_mask = m; access_wait = w; req_valid = 1;
    @(posedge clk); #1;
    if (junk) begin
      req_write = 1; req_addr = a ^ 16'h0004; req_wdata = 16'hFFFF; req_mask = 2'b11;
    end else begin
      req_valid = 0;
    end
    if (wr && m != 0) begin
      shadow[slot(a)] = (shadow[slot(a)] & ~lanes(m)) | (d & lanes(m));
    end
    exp_rd = shadow[slot(a)] & lanes(m);
    forever begin
      @(negedge clk);
      cyc++;
      if (!ram_oe_n && last_oe) gap_bad = 1;
      if (ram_dq_oe && !ram_oe_n) gap_bad = 1;
      last_oe = ram_dq_oe;
      if (!ram_ce_n) begin
        ce_lo++;
        if (ram_addr != a || ram_lb_n != !m[0] || ram_ub_n != !m[1]) pin_bad = 1;
        if (wr && ram_dq_out != d) pin_bad = 1;
      end
      if (!ram_we_n) begin we_lo++; if (first_we < 0) first_we = cyc; end
      if (!ram_oe_n) oe_lo++;
      if (rsp_valid) begin rsp_n++; rsp_cyc = cyc; got = rsp_rdata; end
      if (req_ready) begin
        if (junk) req_valid = 0;
        break;
      end
      if (cyc > 40) break;
    end
    if (m == 0) begin end_exp = 2; ce_exp = 0; end
    else if (wr) begin end_exp = w + 4; ce_exp = w + 3; end
    else begin end_exp = w + 3; ce_exp = w + 1; end
    chk(cyc == end_exp, wr ? "R2 write busy length" : "R4 read busy length", cyc, end_exp);
    chk(ce_lo == ce_exp, (m == 0) ? "R7 no strobe on empty mask" : "R9 chip enable window", ce_lo, ce_exp);
    chk(!pin_bad, "R3 address lanes data steady", pin_bad, 0);
    chk(!gap_bad, "R6 bus turnaround", gap_bad, 0);
    chk(ram_ce_n && !ram_dq_oe, "R1 idle standby", {ram_ce_n, ram_dq_oe}, 2'b10);
    if (wr) begin
      chk(we_lo == ((m == 0) ? 0 : w + 1), "R2 write strobe width", we_lo, (m == 0) ? 0 : w + 1);
      if (m != 0) chk(first_we == 2, "R2 setup cycle", first_we, 2);
      chk(rsp_n == 0, "R4 no response on write", rsp_n, 0);
    end else begin
      chk(oe_lo == ((m == 0) ? 0 : w + 1), "R4 output strobe width", oe_lo, (m == 0) ? 0 : w + 1);
      chk(rsp_n == 1 && rsp_cyc == ((m == 0) ? 1 : w + 2), "R4 response pulse timing",
          rsp_cyc, (m == 0) ? 1 : w + 2);
      chk(got == exp_rd, (m == 0) ? "R7 empty read is zero" : "R5 read data lanes", got, exp_rd);
    end
  endtask

  logic [15:0] addrs [5];
  initial begin
    addrs[0] = 16'h0000; addrs[1] = 16'hFFFF; addrs[2] = 16'h1235;
    addrs[3] = 16'hA5A2; addrs[4] = 16'h7FF3;
    for (int i = 0; i < 16; i++) begin rmem[i] = 0; shadow[i] = 0; end
    repeat (3) @(negedge clk);
    chk(ram_ce_n && ram_we_n && ram_oe_n && ram_ub_n && ram_lb_n && !ram_dq_oe && req_ready && !rsp_valid,
        "R1 reset state", {ram_ce_n, ram_we_n, ram_oe_n, ram_ub_n, ram_lb_n, ram_dq_oe, req_ready, rsp_valid},
        8'b11111010);
    rst_n = 1;
    @(negedge clk);
    for (int wi = 0; wi < 5; wi++) begin
      logic [3:0] w = (wi == 4) ? 4'd15 : 4'(wi);
      for (int ai = 0; ai < 5; ai++) begin
        for (int m = 0; m < 4; m++) begin
          logic [15:0] d = 16'(addrs[ai] * 7 + w * 16'h1111 + m * 16'h0F0F + 16'h3C5A);
          access(1, addrs[ai], d, 2'(m), w, 0);
          access(0, addrs[ai], 16'h0, 2'b11, w, 0);
          access(0, addrs[ai], 16'h0, 2'(m), w, 0);
        end
      end
    end
    access(0, 16'h1235, 16'h0, 2'b01, 4'd2, 1);
    access(0, 16'h1231, 16'h0, 2'b11, 4'd0, 0);
    chk(shadow[slot(16'h1231)] == rmem[slot(16'h1231)], "R8 busy request ignored",
        rmem[slot(16'h1231)], shadow[slot(16'h1231)]);
    access(1, 16'h7FF3, 16'hBEEF, 2'b10, 4'd1, 1);
    access(0, 16'h7FF7, 16'h0, 2'b11, 4'd1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule